// File: doc/BRIEF.md
# SCL-Paced Conversion Stream Reader

This block is the target side of a two-wire serial read in which the bus clock itself paces a converter. After a START and an address byte that matches the block's address with the read bit set, it acknowledges. On the acknowledge clock it tells the converter to start tracking. Two SCL rising edges later it strobes hold-and-convert. The result is then shifted out MSB first on SDA, straight from the capture register, with no queue in between. Each result fills a two-byte frame. The block goes on converting and sending frames for as long as the controller acknowledges, so the controller never has to address the block again to get new samples.

The channel to convert comes from a scan code and a channel select. SDA is open-drain: the block only ever asks for the line to be pulled low. A STOP, a repeated START or a not-acknowledge ends the stream. A watchdog on SCL activity ends a stalled transfer and raises an error flag. The analog front end is a stub interface: a track level, a one-cycle hold strobe, a channel number and a result bus.

Top module: `scl_paced_readout`

## Requirements
- R1: After reset, sda_pull_o, adc_track_o, adc_hold_o and tmo_err_o are all 0.
- R2: After a START, the block samples eight bits on SCL rising edges, MSB first. If the first seven equal DEV_ADDR and the eighth (read flag) is 1, it pulls SDA low for the ninth clock. If not, it never pulls SDA and never starts tracking until the next START.
- R3: adc_track_o rises on the ninth rising SCL edge after START, which is the acknowledge clock. At the second rising edge after tracking starts, adc_hold_o pulses for one cycle and adc_track_o falls. For every later frame, tracking starts on the rising edge of the acknowledge clock that follows the low byte, and hold follows two rising edges later.
- R4: A frame is 16 bits sent MSB first, with an acknowledge slot after every 8 bits. The first PAD = 16 - RES_W bits are released (read as 1). The remaining bits are the result, taken from adc_result_i on the SCL falling edge that begins the first result bit. With RES_W = 10, the first byte is six ones followed by result bits 9 and 8, and the second byte is result bits 7 to 0.
- R5: Frames repeat without limit while every byte is acknowledged (SDA low on the ninth clock). If SDA is high in any acknowledge slot, the stream ends: SDA stays released, and there is no further track or hold until the next START.
- R6: Scan code 00 converts channels 0, 1, ..., chan_sel_i in turn and then wraps back to 0. Codes 01, 10 and 11 all convert chan_sel_i in every frame. adc_chan_o is updated when tracking starts and holds that value through the hold strobe.
- R7: A STOP (SDA rising while SCL is high) or a repeated START (SDA falling while SCL is high) at any bit position releases SDA and drops adc_track_o. A STOP returns the block to idle. A repeated START begins a new address phase.
- R8: sda_pull_o changes only in the cycle after SCL was sampled low. The one exception is the watchdog release.
- R9: If SCL holds one level for TMO_CYC clock cycles while a transfer is active, tmo_err_o rises, SDA is released, tracking drops, and the block goes idle. The next START clears tmo_err_o. The watchdog never fires while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample (resolved line) |
| scan_mode_i | input | 2 | Scan code |
| chan_sel_i | input | CH_W | Channel select (top channel of an up-scan) |
| adc_result_i | input | RES_W | Converter result |
| sda_pull_o | output | 1 | 1 pulls SDA low; 0 releases it |
| adc_track_o | output | 1 | Converter tracking the selected input |
| adc_hold_o | output | 1 | One-cycle hold-and-convert strobe |
| adc_chan_o | output | CH_W | Channel being converted |
| tmo_err_o | output | 1 | SCL stall error flag |

## Verification
The bench builds the block with two channels, a 10-bit result and TMO_CYC = 40, and runs SCL at four system clocks per phase. At these settings the bench can sweep every scan code with every channel select over multi-frame streams, and the up-scan wraps inside a few frames. A stall on a short watchdog limit can be provoked inside one acknowledge slot. A stub converter gives every hold a distinct result, so each frame's bits, hold edge and channel can be predicted arithmetically.

// File: rtl/scl_paced_pkg.sv
package scl_paced_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_TX,
        PH_MACK
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;

endpackage

// File: rtl/scl_bus_events.sv
module scl_bus_events
    import scl_paced_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d.scl  = scl_i;
        smp_d.sda  = sda_i;
        ev_o.rise  = scl_i & ~smp_q.scl;
        ev_o.fall  = ~scl_i & smp_q.scl;
        ev_o.start = scl_i & smp_q.scl & smp_q.sda & ~sda_i;
        ev_o.stop  = scl_i & smp_q.scl & ~smp_q.sda & sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '{scl: 1'b1, sda: 1'b1};
        else        smp_q <= smp_d;
    end

endmodule

// File: rtl/scl_idle_timer.sv
module scl_idle_timer #(
    parameter int TMO_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic edge_i,
    output logic expire_o
);

    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = 1'b0;
        cnt_d    = cnt_q;
        if (!active_i || edge_i) begin
            cnt_d = '0;
        end else if (cnt_q == LIMIT) begin
            expire_o = 1'b1;
            cnt_d    = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/scl_chan_seq.sv
module scl_chan_seq #(
    parameter int CH_W = 1
) (
    input  logic [1:0]      scan_i,
    input  logic [CH_W-1:0] sel_i,
    input  logic [CH_W-1:0] cur_i,
    output logic [CH_W-1:0] first_o,
    output logic [CH_W-1:0] next_o
);

    logic up_scan;

    always_comb begin
        up_scan = (scan_i == 2'b00);
        if (up_scan) begin
            first_o = '0;
            next_o  = (cur_i >= sel_i) ? '0 : cur_i + 1'b1;
        end else begin
            first_o = sel_i;
            next_o  = sel_i;
        end
    end

endmodule

// File: rtl/scl_paced_readout.sv
module scl_paced_readout
    import scl_paced_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h4B,
    parameter int NCH      = 2,
    parameter int RES_W    = 10,
    parameter int TMO_CYC  = 3000,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [1:0]       scan_mode_i,
    input  logic [CH_W-1:0]  chan_sel_i,
    input  logic [RES_W-1:0] adc_result_i,
    output logic             sda_pull_o,
    output logic             adc_track_o,
    output logic             adc_hold_o,
    output logic [CH_W-1:0]  adc_chan_o,
    output logic             tmo_err_o
);

    localparam int POS_W = $clog2(FRAME_W);
    localparam int PAD   = FRAME_W - RES_W;
    localparam logic [POS_W-1:0] HOLD_POS = POS_W'(1);
    localparam logic [POS_W-1:0] PAD_POS  = POS_W'(PAD);
    localparam logic [POS_W-1:0] B0_END   = POS_W'(BYTE_W - 1);
    localparam logic [POS_W-1:0] B1_END   = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] LAST_BIT = POS_W'(FRAME_W - 1);

    typedef struct packed {
        phase_e            st;
        logic [POS_W-1:0]  pos;
        logic [3:0]        acnt;
        logic [7:0]        shreg;
        logic              seen;
        logic              pull;
        logic              track;
        logic              hold;
        logic [RES_W-1:0]  res;
        logic [CH_W-1:0]   chan;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    bus_ev_t          ev;
    logic             tmo_expire;
    logic [CH_W-1:0]  ch_first;
    logic [CH_W-1:0]  ch_next;
    logic [FRAME_W-1:0] fr_cur;
    logic [FRAME_W-1:0] fr_new;
    logic [POS_W-1:0]   pos_inc;

    scl_bus_events u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    scl_idle_timer #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (ctl_q.st != PH_IDLE),
        .edge_i   (ev.rise | ev.fall),
        .expire_o (tmo_expire)
    );

    scl_chan_seq #(.CH_W(CH_W)) u_seq (
        .scan_i  (scan_mode_i),
        .sel_i   (chan_sel_i),
        .cur_i   (ctl_q.chan),
        .first_o (ch_first),
        .next_o  (ch_next)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.hold = 1'b0;
        fr_cur     = {{PAD{1'b1}}, ctl_q.res};
        fr_new     = {{PAD{1'b1}}, adc_result_i};
        pos_inc    = ctl_q.pos + 1'b1;

        unique case (ctl_q.st)
            PH_IDLE: begin
                ctl_d.pull  = 1'b0;
                ctl_d.track = 1'b0;
            end

            PH_ADDR: begin
                if (ev.rise) begin
                    ctl_d.shreg = {ctl_q.shreg[6:0], sda_i};
                    ctl_d.acnt  = ctl_q.acnt + 1'b1;
                end else if (ev.fall && ctl_q.acnt == 4'd8) begin
                    if (ctl_q.shreg[7:1] == DEV_ADDR && ctl_q.shreg[0]) begin
                        ctl_d.st   = PH_AACK;
                        ctl_d.pull = 1'b1;
                        ctl_d.seen = 1'b0;
                    end else begin
                        ctl_d.st = PH_IDLE;
                    end
                end
            end

            PH_AACK: begin
                if (ev.rise) begin
                    ctl_d.seen  = 1'b1;
                    ctl_d.track = 1'b1;
                    ctl_d.chan  = ch_first;
                end else if (ev.fall && ctl_q.seen) begin
                    ctl_d.st   = PH_TX;
                    ctl_d.pos  = '0;
                    ctl_d.pull = ~fr_cur[LAST_BIT];
                end
            end

            PH_TX: begin
                if (ev.rise && ctl_q.pos == HOLD_POS) begin
                    ctl_d.hold  = 1'b1;
                    ctl_d.track = 1'b0;
                end else if (ev.fall) begin
                    if (ctl_q.pos == B0_END || ctl_q.pos == B1_END) begin
                        ctl_d.st   = PH_MACK;
                        ctl_d.pull = 1'b0;
                        ctl_d.seen = 1'b0;
                    end else begin
                        ctl_d.pos = pos_inc;
                        if (pos_inc == PAD_POS) begin
                            ctl_d.res  = adc_result_i;
                            ctl_d.pull = ~fr_new[LAST_BIT - pos_inc];
                        end else begin
                            ctl_d.pull = ~fr_cur[LAST_BIT - pos_inc];
                        end
                    end
                end
            end

            PH_MACK: begin
                if (ev.rise) begin
                    ctl_d.seen = 1'b1;
                    if (sda_i) begin
                        ctl_d.st   = PH_IDLE;
                        ctl_d.pull = 1'b0;
                    end else if (ctl_q.pos == B1_END) begin
                        ctl_d.track = 1'b1;
                        ctl_d.chan  = ch_next;
                    end
                end else if (ev.fall && ctl_q.seen) begin
                    ctl_d.st   = PH_TX;
                    ctl_d.pos  = pos_inc;
                    ctl_d.pull = ~fr_cur[LAST_BIT - pos_inc];
                end
            end

            default: begin
                ctl_d.st = PH_IDLE;
            end
        endcase

        if (tmo_expire) begin
            ctl_d.st    = PH_IDLE;
            ctl_d.err   = 1'b1;
            ctl_d.pull  = 1'b0;
            ctl_d.track = 1'b0;
            ctl_d.hold  = 1'b0;
        end

        if (ev.stop) begin
            ctl_d.st    = PH_IDLE;
            ctl_d.pull  = 1'b0;
            ctl_d.track = 1'b0;
            ctl_d.hold  = 1'b0;
        end

        if (ev.start) begin
            ctl_d.st    = PH_ADDR;
            ctl_d.acnt  = '0;
            ctl_d.shreg = '0;
            ctl_d.err   = 1'b0;
            ctl_d.pull  = 1'b0;
            ctl_d.track = 1'b0;
            ctl_d.hold  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: PH_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_pull_o  = ctl_q.pull;
    assign adc_track_o = ctl_q.track;
    assign adc_hold_o  = ctl_q.hold;
    assign adc_chan_o  = ctl_q.chan;
    assign tmo_err_o   = ctl_q.err;

endmodule

// File: rtl/scl_paced_readout_chk.sv
module scl_paced_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_pull_o,
    input logic adc_track_o,
    input logic adc_hold_o,
    input logic tmo_err_o
);

    AST_PULL_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> (!$past(scl_i) || tmo_err_o)); // R8

    AST_HOLD_NEEDS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        adc_hold_o |-> $past(adc_track_o)); // R3

    AST_HOLD_ENDS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        adc_hold_o |-> !adc_track_o); // R3

    AST_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_hold_o |-> ($past(scl_i) && !$past(scl_i, 2))); // R3

    AST_TRACK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_track_o) |-> ($past(scl_i) && !$past(scl_i, 2))); // R3

    AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_hold_o |=> !adc_hold_o); // R3

    AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err_o) |-> (!sda_pull_o && !adc_track_o)); // R9

endmodule

bind scl_paced_readout scl_paced_readout_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_i),
    .sda_pull_o  (sda_pull_o),
    .adc_track_o (adc_track_o),
    .adc_hold_o  (adc_hold_o),
    .tmo_err_o   (tmo_err_o)
);

// File: tb/scl_paced_readout_test.sv
`timescale 1ns/1ps
module scl_paced_readout_test;

    localparam logic [6:0] ADDR = 7'h4B;
    localparam int TMO = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_pull = 1'b0;
    logic [1:0] scan = 2'b00;
    logic [0:0] sel = 1'b0;
    logic [9:0] adc_res = '0;
    logic sda_pull_o, adc_track_o, adc_hold_o, tmo_err_o;
    logic [0:0] adc_chan_o;
    logic sda_line;

    int nchk = 0, nfail = 0;
    int rise_cnt = 0;
    int hold_n = 0, hold_rise = 0, hold_chan = 0, track_rise = 0;
    logic trk_d = 1'b0;
    logic pull_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = ~(m_pull | sda_pull_o);

    scl_paced_readout #(.DEV_ADDR(ADDR), .NCH(2), .RES_W(10), .TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .scan_mode_i(scan), .chan_sel_i(sel), .adc_result_i(adc_res),
        .sda_pull_o(sda_pull_o), .adc_track_o(adc_track_o), .adc_hold_o(adc_hold_o),
        .adc_chan_o(adc_chan_o), .tmo_err_o(tmo_err_o)
    );

    function automatic logic [9:0] res_of(int n, int ch);
        return 10'((n * 173 + ch * 300 + 5) % 1024);
    endfunction

    // stub converter: each hold produces a new, predictable sample
    always @(posedge clk) begin
        trk_d <= adc_track_o;
        if (adc_track_o && !trk_d) track_rise <= rise_cnt;
        if (adc_hold_o) begin
            hold_n    <= hold_n + 1;
            hold_rise <= rise_cnt;
            hold_chan <= int'(adc_chan_o);
            adc_res   <= res_of(hold_n + 1, int'(adc_chan_o));
        end
    end

    task automatic check_eq(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R8: the pull request may only move while SCL is low (watchdog excepted)
    always @(negedge clk) begin
        if (rst_n && sda_pull_o != pull_prev) begin
            check_eq("R8 pull change with SCL high", int'(scl && !tmo_err_o), 0);
        end
        pull_prev = sda_pull_o;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic r);
        m_pull = ~b;
        wait_clk(4);
        scl = 1'b1;
        rise_cnt++;
        wait_clk(2);
        r = sda_line;
        wait_clk(2);
        scl = 1'b0;
    endtask

    task automatic do_start();
        m_pull = 1'b0;
        wait_clk(4);
        scl = 1'b1;
        wait_clk(4);
        m_pull = 1'b1;
        wait_clk(4);
        scl = 1'b0;
        rise_cnt = 0;
    endtask

    task automatic do_stop();
        m_pull = 1'b1;
        wait_clk(4);
        scl = 1'b1;
        wait_clk(4);
        m_pull = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) bitx(v[i], r);
    endtask

    task automatic send_addr(input logic [6:0] a, input logic rd, output logic ack);
        send_byte({a, rd});
        bitx(1'b1, ack);
    endtask

    task automatic read_byte(input logic ackb, output logic [7:0] d);
        logic r;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bitx(1'b1, r);
            d = {d[6:0], r};
        end
        bitx(ackb, r);
    endtask

    task automatic idle_bits(input int n, output int ones);
        logic r;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            bitx(1'b1, r);
            ones += int'(r);
        end
    endtask

    task automatic run_stream(input logic [1:0] sc, input int sl, input int nfr);
        logic ack;
        logic [7:0] hi, lo;
        int h0, ch, ones;
        scan = sc;
        sel  = 1'(sl);
        h0   = hold_n;
        do_start();
        send_addr(ADDR, 1'b1, ack);
        check_eq("R2 ack on matching read", int'(ack), 0);
        check_eq("R3 track after ack clock", int'(adc_track_o), 1);
        check_eq("R3 track starts at rise 9", track_rise, 9);
        for (int k = 0; k < nfr; k++) begin
            ch = (sc == 2'b00) ? (k % (sl + 1)) : sl;
            read_byte(1'b0, hi);
            read_byte(k == nfr - 1, lo);
            check_eq("R4 frame bits", int'({hi, lo}), int'({6'h3F, res_of(h0 + k + 1, ch)}));
            check_eq("R3 hold two rises after track", hold_rise, 11 + 18 * k);
            check_eq("R6 channel per frame", hold_chan, ch);
            if (k < nfr - 1) begin
                check_eq("R5 next frame tracks after ack", int'(adc_track_o), 1);
                check_eq("R3 next track rise", track_rise, 9 + 18 * (k + 1));
            end
        end
        check_eq("R5 released after nack", int'(sda_pull_o), 0);
        idle_bits(9, ones);
        check_eq("R5 line high after nack", ones, 9);
        check_eq("R5 no hold after nack", hold_n, h0 + nfr);
        check_eq("R5 no track after nack", int'(adc_track_o), 0);
        do_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog (all requirements) actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        logic ack;
        logic [7:0] hi, lo;
        int h0, ones;

        wait_clk(5);
        check_eq("R1 pull in reset", int'(sda_pull_o), 0);
        rst_n = 1'b1;
        wait_clk(3);
        check_eq("R1 pull after reset", int'(sda_pull_o), 0);
        check_eq("R1 track after reset", int'(adc_track_o), 0);
        check_eq("R1 hold after reset", int'(adc_hold_o), 0);
        check_eq("R1 err after reset", int'(tmo_err_o), 0);
        wait_clk(100);
        check_eq("R9 no timeout while idle", int'(tmo_err_o), 0);

        // wrong address
        h0 = hold_n;
        do_start();
        send_addr(ADDR ^ 7'h01, 1'b1, ack);
        check_eq("R2 no ack on other address", int'(ack), 1);
        idle_bits(20, ones);
        check_eq("R2 silent on other address", ones, 20);
        check_eq("R2 no hold on other address", hold_n, h0);
        do_stop();

        // write direction
        do_start();
        send_addr(ADDR, 1'b0, ack);
        check_eq("R2 no ack on write", int'(ack), 1);
        idle_bits(20, ones);
        check_eq("R2 no hold on write", hold_n, h0);
        check_eq("R2 no track on write", int'(adc_track_o), 0);
        do_stop();

        // sweep every scan code and channel select
        for (int sc = 0; sc < 4; sc++)
            for (int sl = 0; sl < 2; sl++)
                run_stream(2'(sc), sl, 4);

        // nack after the high byte
        h0 = hold_n;
        scan = 2'b01; sel = 1'b1;
        do_start();
        send_addr(ADDR, 1'b1, ack);
        read_byte(1'b1, hi);
        check_eq("R4 high byte", int'(hi), int'({6'h3F, res_of(h0 + 1, 1)} >> 8));
        check_eq("R5 released after high-byte nack", int'(sda_pull_o), 0);
        idle_bits(18, ones);
        check_eq("R5 silent after high-byte nack", ones, 18);
        check_eq("R5 single hold after high-byte nack", hold_n, h0 + 1);
        do_stop();

        // STOP right after the address acknowledge
        h0 = hold_n;
        do_start();
        send_addr(ADDR, 1'b1, ack);
        check_eq("R7 tracking before stop", int'(adc_track_o), 1);
        do_stop();
        check_eq("R7 track dropped by stop", int'(adc_track_o), 0);
        check_eq("R7 released by stop", int'(sda_pull_o), 0);
        idle_bits(20, ones);
        check_eq("R7 idle after stop", hold_n, h0);

        // repeated START inside the pad bits, then a fresh frame
        do_start();
        send_addr(ADDR, 1'b1, ack);
        idle_bits(4, ones);
        check_eq("R7 pad bits before restart", ones, 4);
        h0 = hold_n;
        do_start();
        check_eq("R7 released by restart", int'(sda_pull_o), 0);
        check_eq("R7 track low after restart", int'(adc_track_o), 0);
        send_addr(ADDR, 1'b1, ack);
        check_eq("R7 ack after restart", int'(ack), 0);
        read_byte(1'b0, hi);
        read_byte(1'b1, lo);
        check_eq("R7 frame after restart", int'({hi, lo}), int'({6'h3F, res_of(h0 + 1, 1)}));
        do_stop();

        // SCL stall during the address acknowledge
        do_start();
        send_byte({ADDR, 1'b1});
        m_pull = 1'b0;
        wait_clk(4);
        check_eq("R2 ack pull during stall", int'(sda_pull_o), 1);
        wait_clk(TMO + 20);
        check_eq("R9 error after stall", int'(tmo_err_o), 1);
        check_eq("R9 release after stall", int'(sda_pull_o), 0);
        h0 = hold_n;
        do_start();
        check_eq("R9 error cleared by start", int'(tmo_err_o), 0);
        send_addr(ADDR, 1'b1, ack);
        check_eq("R9 ack after recovery", int'(ack), 0);
        read_byte(1'b0, hi);
        read_byte(1'b1, lo);
        check_eq("R9 frame after recovery", int'({hi, lo}), int'({6'h3F, res_of(h0 + 1, 1)}));
        do_stop();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule